// File: doc/BRIEF.md
# BCD Calendar Date Counter

The block holds a calendar date as packed BCD: a four-digit year, a two-digit month and a two-digit day. On each single-cycle day-tick pulse from the time-of-day counter, the date moves forward one day. Day, month and year wrap in a chain, with month lengths that follow the calendar and a February that changes with the leap year. The supported years run from 2000 to 2100. After 2100 the year returns to 2000.

Three increment requests set the date by hand. Each one advances a single field and leaves the other fields unchanged. The day is pulled back when it would fall outside the new month. The design is fully synchronous on one clock. Every input acts as a clock enable.

Top module: `cal_date_counter`

## Requirements
- R1: After reset, and after any later assertion of the asynchronous reset, the date is year 16'h2000, month 8'h01, day 8'h01.
- R2: A day tick on a day that is not the last of its month advances the day by one in BCD (8'h09 becomes 8'h10) and leaves month and year unchanged.
- R3: Months 01, 03, 05, 07, 08, 10 and 12 last 31 days. Months 04, 06, 09 and 11 last 30 days. A day tick on the last day sets the day to 01 and advances the month.
- R4: February lasts 29 days in the years 2000 to 2096 that are divisible by 4. It lasts 28 days in every other year, including 2100.
- R5: A day tick on December 31 gives January 01 of the following year. The year increment ripples a carry through all four BCD digits (2009 to 2010, 2099 to 2100).
- R6: Year 2100 is followed by 2000, both on a day tick from 2100-12-31 and on a year increment request.
- R7: The day increment request (inc_day_i) advances only the day. The day wraps from the month's last day to 01 without changing the month. If held high for N cycles, it advances N times.
- R8: The month increment request advances only the month, with 12 followed by 01 and the year unchanged. If the day is past the new month's length, it is clamped to that month's last day.
- R9: The year increment request advances only the year, with the month unchanged. If February 29 becomes invalid, the day is clamped to 28.
- R10: With no tick and no request, the date holds.
- R11: When several inputs are high in one cycle, they apply in this order: tick, then day, then month, then year. Each step acts on the result of the step before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| day_tick_i | input | 1 | Advance the date by one day |
| inc_day_i | input | 1 | Manual day increment |
| inc_mon_i | input | 1 | Manual month increment |
| inc_year_i | input | 1 | Manual year increment |
| year_o | output | 16 | Year, four BCD digits |
| month_o | output | 8 | Month, two BCD digits |
| day_o | output | 8 | Day, two BCD digits |

## Verification
The assertions assume that every input is synchronous to clk_i and never unknown. They also assume that reset is held across at least one rising edge before it is released. Under those assumptions, the date registers can only reach valid dates. The bench changes every input on the falling edge and releases reset on a falling edge. It reaches each start date only through the block's own increment requests, so no state is ever forced into the design.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int YEAR_DIGITS = 4;
  localparam int YEAR_W      = 4 * YEAR_DIGITS;
  localparam int FIELD_W     = 8;
  localparam logic [YEAR_W-1:0] YEAR_MIN = 16'h2000;
  localparam logic [YEAR_W-1:0] YEAR_MAX = 16'h2100;

  typedef struct packed {
    logic [YEAR_W-1:0]  year;
    logic [FIELD_W-1:0] month;
    logic [FIELD_W-1:0] day;
  } date_t;

  typedef enum logic [1:0] {OP_TICK, OP_DAY, OP_MON, OP_YEAR} cal_op_e;

  function automatic logic [FIELD_W-1:0] bcd2_inc(input logic [FIELD_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // valid for 2000..2100: divisible by 4 from the two low BCD digits, 2100 excluded
  function automatic logic is_leap(input logic [YEAR_W-1:0] y);
    logic div4;
    if (y[4]) div4 = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      div4 = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return div4 && (y != YEAR_MAX);
  endfunction

  function automatic logic [FIELD_W-1:0] month_len(input logic [FIELD_W-1:0] m,
                                                   input logic [YEAR_W-1:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_year_inc.sv
module cal_year_inc
  import cal_pkg::*;
#(
  parameter int DIGITS = YEAR_DIGITS
) (
  input  logic [4*DIGITS-1:0] year_i,
  output logic [4*DIGITS-1:0] year_o
);
  logic [DIGITS-1:0]   carry;
  logic [4*DIGITS-1:0] raw;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] d;
    assign d = year_i[4*i +: 4];
    assign raw[4*i +: 4] = !carry[i] ? d : (d == 4'd9) ? 4'd0 : d + 4'd1;
    if (i < DIGITS - 1) begin : g_cy
      assign carry[i+1] = carry[i] && (d == 4'd9);
    end
  end

  assign year_o = (year_i == YEAR_MAX) ? YEAR_MIN : raw;
endmodule

// File: rtl/cal_step.sv
module cal_step
  import cal_pkg::*;
#(
  parameter cal_op_e OP = OP_TICK
) (
  input  date_t date_i,
  input  logic  en_i,
  output date_t date_o
);
  if (OP == OP_TICK) begin : g_tick
    logic [FIELD_W-1:0] last;
    logic [YEAR_W-1:0]  yr_nx;
    assign last = month_len(date_i.month, date_i.year);
    cal_year_inc u_yinc (.year_i(date_i.year), .year_o(yr_nx));
    always_comb begin
      date_o = date_i;
      if (en_i) begin
        if (date_i.day == last) begin
          date_o.day = 8'h01;
          if (date_i.month == 8'h12) begin
            date_o.month = 8'h01;
            date_o.year  = yr_nx;
          end else begin
            date_o.month = bcd2_inc(date_i.month);
          end
        end else begin
          date_o.day = bcd2_inc(date_i.day);
        end
      end
    end
  end else if (OP == OP_DAY) begin : g_day
    logic [FIELD_W-1:0] last;
    assign last = month_len(date_i.month, date_i.year);
    always_comb begin
      date_o = date_i;
      if (en_i) date_o.day = (date_i.day == last) ? 8'h01 : bcd2_inc(date_i.day);
    end
  end else if (OP == OP_MON) begin : g_mon
    logic [FIELD_W-1:0] mon_nx, last;
    assign mon_nx = (date_i.month == 8'h12) ? 8'h01 : bcd2_inc(date_i.month);
    assign last   = month_len(mon_nx, date_i.year);
    always_comb begin
      date_o = date_i;
      if (en_i) begin
        date_o.month = mon_nx;
        if (date_i.day > last) date_o.day = last;
      end
    end
  end else begin : g_year
    logic [YEAR_W-1:0]  yr_nx;
    logic [FIELD_W-1:0] last;
    cal_year_inc u_yinc (.year_i(date_i.year), .year_o(yr_nx));
    assign last = month_len(date_i.month, yr_nx);
    always_comb begin
      date_o = date_i;
      if (en_i) begin
        date_o.year = yr_nx;
        if (date_i.day > last) date_o.day = last;
      end
    end
  end
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
  import cal_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               day_tick_i,
  input  logic               inc_day_i,
  input  logic               inc_mon_i,
  input  logic               inc_year_i,
  output logic [YEAR_W-1:0]  year_o,
  output logic [FIELD_W-1:0] month_o,
  output logic [FIELD_W-1:0] day_o
);
  localparam int N_STEPS = 4;

  date_t              date_q;
  date_t              chain [N_STEPS+1];
  logic [N_STEPS-1:0] en_vec;

  // order of application: tick, day, month, year
  assign en_vec   = {inc_year_i, inc_mon_i, inc_day_i, day_tick_i};
  assign chain[0] = date_q;

  for (genvar i = 0; i < N_STEPS; i++) begin : g_step
    cal_step #(.OP(cal_op_e'(i))) u_step (
      .date_i(chain[i]),
      .en_i  (en_vec[i]),
      .date_o(chain[i+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) date_q <= '{year: YEAR_MIN, month: 8'h01, day: 8'h01};
    else         date_q <= chain[N_STEPS];
  end

  assign year_o  = date_q.year;
  assign month_o = date_q.month;
  assign day_o   = date_q.day;
endmodule

// File: rtl/cal_date_chk.sv
module cal_date_chk
  import cal_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               day_tick_i,
  input logic               inc_day_i,
  input logic               inc_mon_i,
  input logic               inc_year_i,
  input logic [YEAR_W-1:0]  year_o,
  input logic [FIELD_W-1:0] month_o,
  input logic [FIELD_W-1:0] day_o
);
  logic any_in;
  assign any_in = day_tick_i | inc_day_i | inc_mon_i | inc_year_i;

  a_r3_date_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    month_o >= 8'h01 && month_o <= 8'h12 && month_o[3:0] <= 4'd9 &&
    day_o >= 8'h01 && day_o <= month_len(month_o, year_o) && day_o[3:0] <= 4'd9);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_in |=> $stable(year_o) && $stable(month_o) && $stable(day_o));

  a_r2_tick_moves_day: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_tick_i && !inc_day_i && !inc_mon_i && !inc_year_i |=> day_o != $past(day_o));

  a_r7_day_key_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_day_i && !day_tick_i && !inc_mon_i && !inc_year_i
    |=> $stable(month_o) && $stable(year_o) && day_o != $past(day_o));

  a_r8_mon_key_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_mon_i && !day_tick_i && !inc_day_i && !inc_year_i
    |=> $stable(year_o) && month_o != $past(month_o));

  a_r9_year_key_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_year_i && !day_tick_i && !inc_day_i && !inc_mon_i
    |=> $stable(month_o) && year_o != $past(year_o));

  a_r6_range_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_tick_i && !inc_day_i && !inc_mon_i && !inc_year_i &&
    year_o == 16'h2100 && month_o == 8'h12 && day_o == 8'h31
    |=> year_o == 16'h2000 && month_o == 8'h01 && day_o == 8'h01);
endmodule

bind cal_date_counter cal_date_chk u_chk (.*);

// File: tb/cal_date_counter_tb.sv
module cal_date_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ctl = '0;  // bit0 tick, bit1 day, bit2 month, bit3 year
  logic [15:0] year;
  logic [7:0]  month, day;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5ns clk = ~clk;

  cal_date_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .day_tick_i(ctl[0]), .inc_day_i(ctl[1]), .inc_mon_i(ctl[2]), .inc_year_i(ctl[3]),
    .year_o(year), .month_o(month), .day_o(day)
  );

  // {req, start y, m, d, ctl mask, expected y, m, d}
  localparam int NV = 22;
  localparam logic [71:0] VEC [NV] = '{
    {4'd2,  16'h2000, 8'h01, 8'h09, 4'b0001, 16'h2000, 8'h01, 8'h10}, // R2
    {4'd3,  16'h2000, 8'h01, 8'h31, 4'b0001, 16'h2000, 8'h02, 8'h01}, // R3
    {4'd3,  16'h2001, 8'h04, 8'h30, 4'b0001, 16'h2001, 8'h05, 8'h01}, // R3
    {4'd4,  16'h2004, 8'h02, 8'h28, 4'b0001, 16'h2004, 8'h02, 8'h29}, // R4
    {4'd4,  16'h2004, 8'h02, 8'h29, 4'b0001, 16'h2004, 8'h03, 8'h01}, // R4
    {4'd4,  16'h2003, 8'h02, 8'h28, 4'b0001, 16'h2003, 8'h03, 8'h01}, // R4
    {4'd4,  16'h2100, 8'h02, 8'h28, 4'b0001, 16'h2100, 8'h03, 8'h01}, // R4
    {4'd4,  16'h2000, 8'h02, 8'h28, 4'b0001, 16'h2000, 8'h02, 8'h29}, // R4
    {4'd5,  16'h2009, 8'h12, 8'h31, 4'b0001, 16'h2010, 8'h01, 8'h01}, // R5
    {4'd5,  16'h2099, 8'h12, 8'h31, 4'b0001, 16'h2100, 8'h01, 8'h01}, // R5
    {4'd6,  16'h2100, 8'h12, 8'h31, 4'b0001, 16'h2000, 8'h01, 8'h01}, // R6
    {4'd6,  16'h2100, 8'h06, 8'h15, 4'b1000, 16'h2000, 8'h06, 8'h15}, // R6
    {4'd7,  16'h2000, 8'h01, 8'h31, 4'b0010, 16'h2000, 8'h01, 8'h01}, // R7
    {4'd7,  16'h2000, 8'h06, 8'h15, 4'b0010, 16'h2000, 8'h06, 8'h16}, // R7
    {4'd8,  16'h2000, 8'h12, 8'h15, 4'b0100, 16'h2000, 8'h01, 8'h15}, // R8
    {4'd8,  16'h2000, 8'h01, 8'h31, 4'b0100, 16'h2000, 8'h02, 8'h29}, // R8
    {4'd8,  16'h2001, 8'h03, 8'h31, 4'b0100, 16'h2001, 8'h04, 8'h30}, // R8
    {4'd9,  16'h2004, 8'h02, 8'h29, 4'b1000, 16'h2005, 8'h02, 8'h28}, // R9
    {4'd9,  16'h2019, 8'h07, 8'h04, 4'b1000, 16'h2020, 8'h07, 8'h04}, // R9
    {4'd10, 16'h2000, 8'h05, 8'h20, 4'b0000, 16'h2000, 8'h05, 8'h20}, // R10
    {4'd11, 16'h2000, 8'h01, 8'h31, 4'b0011, 16'h2000, 8'h02, 8'h02}, // R11
    {4'd11, 16'h2000, 8'h12, 8'h31, 4'b1101, 16'h2002, 8'h02, 8'h01}  // R11
  };

  function automatic int bcd2int(input logic [15:0] v);
    return v[15:12] * 1000 + v[11:8] * 100 + v[7:4] * 10 + v[3:0];
  endfunction

  task automatic check(input string req, input logic [15:0] ey, input logic [7:0] em, ed);
    n_chk++;
    if (year !== ey || month !== em || day !== ed) begin
      n_fail++;
      $display("FAIL %s: got %h-%h-%h expected %h-%h-%h", req, year, month, day, ey, em, ed);
    end
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ctl = m;
      @(negedge clk) ctl = '0;
    end
  endtask

  task automatic set_date(input logic [15:0] y, input logic [7:0] m, d);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    pulse(4'b1000, bcd2int(y) - 2000);
    pulse(4'b0100, bcd2int({8'h0, m}) - 1);
    pulse(4'b0010, bcd2int({8'h0, d}) - 1);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", 16'h2000, 8'h01, 8'h01);  // R1 reset state

    for (int v = 0; v < NV; v++) begin
      logic [71:0] e;
      e = VEC[v];
      set_date(e[67:52], e[51:44], e[43:36]);
      check("setup", e[67:52], e[51:44], e[43:36]);
      pulse(e[35:32], 1);
      check($sformatf("R%0d", e[71:68]), e[31:16], e[15:8], e[7:0]);
    end

    // R7: day request held three cycles
    set_date(16'h2000, 8'h03, 8'h01);
    @(negedge clk) ctl = 4'b0010;
    repeat (3) @(negedge clk);
    ctl = '0;
    check("R7", 16'h2000, 8'h03, 8'h04);

    // R10: long idle
    repeat (50) @(negedge clk);
    check("R10", 16'h2000, 8'h03, 8'h04);

    // R1: asynchronous reset mid-run
    #2ns rst_n = 1'b0;
    #1ns check("R1", 16'h2000, 8'h01, 8'h01);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule